// File: doc/BRIEF.md
# Load Data Width and Saturation Formatter

This block turns the raw bytes returned by a memory read into the value written to one destination register element. Each accepted read passes through two pipeline stages. The first stage reorders the bytes when the reversal condition holds, over the operation width only. The second stage adapts the value to the destination element width. It either truncates or zero-extends the value, or it sign-extends the value and then clamps it into the unsigned or signed range of the destination width.

A load unit drives one read per cycle with `inValid` high. The formatted element appears two cycles later with `outValid` high. The block also raises a flag when the memory-side element width is narrower than the operation width, because that combination has no defined result. Placing the element in the register file, address generation and store data are handled elsewhere.

Top module: `ld_data_formatter`

## Requirements
- R1: A result appears with `outValid` high exactly two clock edges after the edge that sampled `inValid` high. `outValid` is low in every other cycle, and one read can be accepted on every cycle.
- R2: The bytes are reversed when `brevOp` equals `leMode`. When the two differ, the byte order is kept.
- R3: Only the low 1, 2, 4 or 8 bytes of `inData` take part, as selected by `opWidth` (width encoding: 2'b00=8, 2'b01=16, 2'b10=32, 2'b11=64 bits). Reversal acts within that span only, and input bytes above it have no effect on the result.
- R4: With `satEn` low, the value is zero-extended or truncated from the operation width to the destination width `dstWidth` (same encoding as R3).
- R5: With `satEn` high and `satSigned` low, the operation-width value is read as unsigned. Any value above 2^w-1 becomes 2^w-1, where w is the destination width.
- R6: With `satEn` and `satSigned` high, the operation-width value is sign-extended and clamped to the range from -2^(w-1) to 2^(w-1)-1. The result is given in w-bit two's complement.
- R7: Every output bit at or above the destination width is zero whenever `outValid` is high.
- R8: `outUndef` is high together with `outValid` when `memWidth` (same encoding as R3) is smaller than `opWidth` for that read. Otherwise `outUndef` is low.
- R9: While `outValid` is low, `outData` keeps the last formatted value.
- R10: During and right after reset, `outValid`, `outUndef` and `outData` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A read is presented this cycle |
| inData | input | 64 | Raw read data, least significant byte first |
| opWidth | input | 2 | Operation width code |
| brevOp | input | 1 | Byte-reversing form of the load |
| leMode | input | 1 | Processor runs little-endian |
| satEn | input | 1 | Saturating conversion enable |
| satSigned | input | 1 | 1 = signed clamp, 0 = unsigned clamp |
| dstWidth | input | 2 | Destination element width code |
| memWidth | input | 2 | Memory-side element width code |
| outValid | output | 1 | Formatted element valid |
| outData | output | 64 | Formatted element, zero above destination width |
| outUndef | output | 1 | Width combination undefined for this read |

## Verification
The hardest cases to reach are the signed clamp boundaries. In these cases the sign bit of a narrow operation width must be carried through an optional byte reversal before it decides between the two clamp limits. The stimulus reaches them with directed reads whose top byte, after reversal, sits exactly at 0x80, 0x7F or all ones. It then adds back-to-back random reads that mix every width code, both endian settings and idle gaps. The gaps expose any hold or latency slip at the output.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  localparam int XLEN = 64;
  localparam int NUM_WIDTHS = $clog2(XLEN / 8) + 1;
  localparam int WSEL_W = $clog2(NUM_WIDTHS);

  typedef enum logic [WSEL_W-1:0] {
    WID8  = 2'd0,
    WID16 = 2'd1,
    WID32 = 2'd2,
    WID64 = 2'd3
  } widthSel_e;

  typedef struct packed {
    logic stage1Load;
    logic stage2Load;
  } stageStrobe_t;

  typedef struct packed {
    logic [XLEN-1:0] value;
    widthSel_e       opWidth;
    logic            satEn;
    logic            satSigned;
    widthSel_e       dstWidth;
    logic            undef;
  } stage1Reg_t;
endpackage

// File: rtl/ldfmt_ctrl.sv
module ldfmt_ctrl
  import ldfmt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);
  logic s1Valid;
  logic s2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= inValid;
      s2Valid <= s1Valid;
    end
  end

  assign strobe.stage1Load = inValid;
  assign strobe.stage2Load = s1Valid;
  assign outValid = s2Valid;
endmodule

// File: rtl/ldfmt_datapath.sv
module ldfmt_datapath
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobe_t      strobe,
  input  logic [DATA_W-1:0] inData,
  input  widthSel_e         opWidth,
  input  logic              brevOp,
  input  logic              leMode,
  input  logic              satEn,
  input  logic              satSigned,
  input  widthSel_e         dstWidth,
  input  widthSel_e         memWidth,
  output logic [DATA_W-1:0] outData,
  output logic              outUndef
);
  localparam int NUM_W = $clog2(DATA_W / 8) + 1;

  // ---------------- stage 1: byte selection and reversal ----------------
  logic [DATA_W-1:0] swapCand  [NUM_W];
  logic [DATA_W-1:0] plainCand [NUM_W];
  logic              swapNeeded;
  stage1Reg_t        s1D;
  stage1Reg_t        s1Q;

  for (genvar k = 0; k < NUM_W; k++) begin : g_opw
    localparam int NB = 1 << k;
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign swapCand[k][8*b +: 8]  = inData[8*(NB-1-b) +: 8];
      assign plainCand[k][8*b +: 8] = inData[8*b +: 8];
    end
    if (NB * 8 < DATA_W) begin : g_pad
      assign swapCand[k][DATA_W-1:NB*8]  = '0;
      assign plainCand[k][DATA_W-1:NB*8] = '0;
    end
  end

  assign swapNeeded = brevOp ~^ leMode;

  always_comb begin
    s1D.value     = swapNeeded ? swapCand[opWidth] : plainCand[opWidth];
    s1D.opWidth   = opWidth;
    s1D.satEn     = satEn;
    s1D.satSigned = satSigned;
    s1D.dstWidth  = dstWidth;
    s1D.undef     = (memWidth < opWidth);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Q <= '0;
    end else if (strobe.stage1Load) begin
      s1Q <= s1D;
    end
  end

  // ---------------- stage 2: extension and clamping ----------------
  logic [DATA_W-1:0] sExt     [NUM_W];
  logic [DATA_W-1:0] truncRes [NUM_W];
  logic [DATA_W-1:0] satRes   [NUM_W];
  logic [DATA_W-1:0] extVal;
  logic [DATA_W-1:0] resD;
  logic [DATA_W-1:0] dataQ;
  logic              undefQ;

  for (genvar k = 0; k < NUM_W; k++) begin : g_sext
    localparam int OB = 8 << k;
    if (OB < DATA_W) begin : g_part
      assign sExt[k] = {{(DATA_W-OB){s1Q.value[OB-1]}}, s1Q.value[OB-1:0]};
    end else begin : g_whole
      assign sExt[k] = s1Q.value;
    end
  end

  assign extVal = (s1Q.satEn && s1Q.satSigned) ? sExt[s1Q.opWidth] : s1Q.value;

  for (genvar d = 0; d < NUM_W; d++) begin : g_dst
    localparam int W = 8 << d;
    if (W < DATA_W) begin : g_narrow
      logic              hiAny;
      logic              fitsSigned;
      logic [DATA_W-1:0] uMax;
      logic [DATA_W-1:0] sMax;
      logic [DATA_W-1:0] sMin;
      assign hiAny      = |extVal[DATA_W-1:W];
      assign fitsSigned = (extVal[DATA_W-1:W-1] == {(DATA_W-W+1){extVal[DATA_W-1]}});
      assign uMax       = {{(DATA_W-W){1'b0}}, {W{1'b1}}};
      assign sMax       = {{(DATA_W-W+1){1'b0}}, {(W-1){1'b1}}};
      assign sMin       = {{(DATA_W-W){1'b0}}, 1'b1, {(W-1){1'b0}}};
      assign truncRes[d] = {{(DATA_W-W){1'b0}}, extVal[W-1:0]};
      assign satRes[d] = s1Q.satSigned
                         ? (fitsSigned ? truncRes[d] : (extVal[DATA_W-1] ? sMin : sMax))
                         : (hiAny ? uMax : truncRes[d]);
    end else begin : g_full
      assign truncRes[d] = extVal;
      assign satRes[d]   = extVal;
    end
  end

  assign resD = s1Q.satEn ? satRes[s1Q.dstWidth] : truncRes[s1Q.dstWidth];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      undefQ <= 1'b0;
    end else begin
      undefQ <= strobe.stage2Load & s1Q.undef;
      if (strobe.stage2Load) begin
        dataQ <= resD;
      end
    end
  end

  assign outData  = dataQ;
  assign outUndef = undefQ;
endmodule

// File: rtl/ld_data_formatter.sv
module ld_data_formatter
  import ldfmt_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [XLEN-1:0] inData,
  input  logic [1:0]      opWidth,
  input  logic            brevOp,
  input  logic            leMode,
  input  logic            satEn,
  input  logic            satSigned,
  input  logic [1:0]      dstWidth,
  input  logic [1:0]      memWidth,
  output logic            outValid,
  output logic [XLEN-1:0] outData,
  output logic            outUndef
);
  stageStrobe_t strobe;

  ldfmt_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  ldfmt_datapath #(.DATA_W(XLEN)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .opWidth   (widthSel_e'(opWidth)),
    .brevOp    (brevOp),
    .leMode    (leMode),
    .satEn     (satEn),
    .satSigned (satSigned),
    .dstWidth  (widthSel_e'(dstWidth)),
    .memWidth  (widthSel_e'(memWidth)),
    .outData   (outData),
    .outUndef  (outUndef)
  );
endmodule

// File: rtl/ld_data_formatter_chk.sv
module ld_data_formatter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [63:0] inData,
  input logic [1:0]  opWidth,
  input logic        satEn,
  input logic [1:0]  dstWidth,
  input logic [1:0]  memWidth,
  input logic        outValid,
  input logic [63:0] outData,
  input logic        outUndef
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= 2'd0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  function automatic logic [63:0] keepMask(input logic [1:0] code);
    case (code)
      2'd0:    keepMask = 64'h0000_0000_0000_00FF;
      2'd1:    keepMask = 64'h0000_0000_0000_FFFF;
      2'd2:    keepMask = 64'h0000_0000_FFFF_FFFF;
      default: keepMask = '1;
    endcase
  endfunction

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2) |-> (outValid == $past(inValid, 2))); // R1

  AST_BYTE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2 && outValid && $past(opWidth, 2) == 2'd0 && !$past(satEn, 2))
      |-> (outData == {56'd0, $past(inData[7:0], 2)})); // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2 && outValid) |-> ((outData & ~keepMask($past(dstWidth, 2))) == 64'd0)); // R7

  AST_UNDEF_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2) |-> (outUndef == ($past(inValid, 2) && ($past(memWidth, 2) < $past(opWidth, 2))))); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !outValid) |-> $stable(outData)); // R9
endmodule

bind ld_data_formatter ld_data_formatter_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inData   (inData),
  .opWidth  (opWidth),
  .satEn    (satEn),
  .dstWidth (dstWidth),
  .memWidth (memWidth),
  .outValid (outValid),
  .outData  (outData),
  .outUndef (outUndef)
);

// File: tb/ld_data_formatter_tb_top.sv
module ld_data_formatter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inData = '0;
  logic [1:0]  opWidth = '0;
  logic        brevOp = 1'b0;
  logic        leMode = 1'b0;
  logic        satEn = 1'b0;
  logic        satSigned = 1'b0;
  logic [1:0]  dstWidth = '0;
  logic [1:0]  memWidth = '0;
  logic        outValid;
  logic [63:0] outData;
  logic        outUndef;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  logic [63:0] lastOut = '0;

  typedef struct {
    bit          v;
    logic [63:0] d;
    bit          u;
    string       tag;
  } expEntry_t;

  expEntry_t pending[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ld_data_formatter dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .opWidth(opWidth), .brevOp(brevOp), .leMode(leMode), .satEn(satEn),
    .satSigned(satSigned), .dstWidth(dstWidth), .memWidth(memWidth),
    .outValid(outValid), .outData(outData), .outUndef(outUndef)
  );

  function automatic logic [63:0] msk(input int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] refFmt(input logic [63:0] data, input int op,
      input bit brev, input bit le, input bit sat, input bit sgn, input int dst);
    int nb = 1 << op;
    int ob = 8 * nb;
    int w  = 8 << dst;
    logic [63:0] v = '0;
    longint s;
    longint hi;
    longint lo;
    for (int b = 0; b < nb; b++) begin
      if (brev == le) v[8*(nb-1-b) +: 8] = data[8*b +: 8];
      else            v[8*b +: 8]        = data[8*b +: 8];
    end
    if (!sat) return v & msk(w);
    if (!sgn) begin
      if (w < 64 && v > msk(w)) return msk(w);
      return v;
    end
    s = (ob < 64 && v[ob-1]) ? longint'(v | ~msk(ob)) : longint'(v);
    if (w < 64) begin
      hi = (64'sd1 <<< (w - 1)) - 64'sd1;
      lo = -(64'sd1 <<< (w - 1));
      if (s > hi) s = hi;
      if (s < lo) s = lo;
    end
    return 64'(s) & msk(w);
  endfunction

  task automatic compareOut();
    expEntry_t e;
    if (pending.size() < 2) return;
    e = pending.pop_front();
    checks++;
    if (outValid !== e.v) begin
      fails++;
      $display("FAIL R1 (%s): outValid actual %0b expected %0b", e.tag, outValid, e.v);
    end else if (e.v && outData !== e.d) begin
      fails++;
      $display("FAIL %s: outData actual %h expected %h", e.tag, outData, e.d);
    end else if (!e.v && outData !== lastOut) begin
      fails++;
      $display("FAIL R9 (%s): outData actual %h expected %h", e.tag, outData, lastOut);
    end else if (outUndef !== e.u) begin
      fails++;
      $display("FAIL R8 (%s): outUndef actual %0b expected %0b", e.tag, outUndef, e.u);
    end
    if (e.v) lastOut = e.d;
  endtask

  task automatic drive(input bit v, input logic [63:0] d, input int op, input bit brev,
      input bit le, input bit sat, input bit sgn, input int dst, input int mem, input string tag);
    expEntry_t e;
    @(negedge clk);
    compareOut();
    inValid = v; inData = d; opWidth = 2'(op); brevOp = brev; leMode = le;
    satEn = sat; satSigned = sgn; dstWidth = 2'(dst); memWidth = 2'(mem);
    e.v = v;
    e.d = refFmt(d, op, brev, le, sat, sgn, dst);
    e.u = v && (mem < op);
    e.tag = tag;
    pending.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, {$urandom, $urandom}, $urandom % 4, 1'b0, 1'b0, 1'b0, 1'b0, 3, 3, tag);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: cycles actual %0d expected below %0d", cycles, WATCHDOG_CYCLES);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R10 reset state
    if (outValid !== 1'b0 || outData !== 64'd0 || outUndef !== 1'b0) begin
      fails++;
      $display("FAIL R10: outputs actual %0b/%h/%0b expected 0/0/0", outValid, outData, outUndef);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++; // R10 right after reset
    if (outValid !== 1'b0 || outData !== 64'd0 || outUndef !== 1'b0) begin
      fails++;
      $display("FAIL R10: outputs actual %0b/%h/%0b expected 0/0/0", outValid, outData, outUndef);
    end

    // R2 reversal condition, 64-bit reads
    drive(1, 64'h0102030405060708, 3, 0, 0, 0, 0, 3, 3, "R2");
    drive(1, 64'h0102030405060708, 3, 1, 0, 0, 0, 3, 3, "R2");
    drive(1, 64'h0102030405060708, 3, 1, 1, 0, 0, 3, 3, "R2");
    drive(1, 64'h0102030405060708, 3, 0, 1, 0, 0, 3, 3, "R2");
    // R3 span limited to operation width, high bytes ignored
    drive(1, 64'hFFFF_FFFF_FFFF_1234, 1, 0, 0, 0, 0, 3, 3, "R3");
    drive(1, 64'hAAAA_AAAA_1234_5678, 2, 1, 1, 0, 0, 3, 3, "R3");
    drive(1, 64'h5555_5555_1234_5678, 2, 1, 1, 0, 0, 3, 3, "R3");
    // R4 truncation and zero extension
    drive(1, 64'h0000_0000_89AB_CDEF, 2, 1, 0, 0, 0, 0, 3, "R4");
    drive(1, 64'h0000_0000_0000_00F0, 0, 1, 0, 0, 0, 3, 3, "R4");
    // R5 unsigned clamp
    drive(1, 64'h0000_0000_0000_1234, 1, 1, 0, 1, 0, 0, 3, "R5");
    drive(1, 64'h0000_0000_0000_0012, 1, 1, 0, 1, 0, 0, 3, "R5");
    drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 3, 1, 0, 1, 0, 2, 3, "R5");
    // R6 signed clamp edges
    drive(1, 64'h0000_0000_0000_8000, 1, 1, 0, 1, 1, 0, 3, "R6");
    drive(1, 64'h0000_0000_0000_7FFF, 1, 1, 0, 1, 1, 0, 3, "R6");
    drive(1, 64'h0000_0000_0000_FFFE, 1, 1, 0, 1, 1, 0, 3, "R6");
    drive(1, 64'h0000_0000_0000_0080, 0, 1, 0, 1, 1, 2, 3, "R6");
    drive(1, 64'h0000_0000_0000_0080, 1, 0, 0, 1, 1, 0, 3, "R6");
    // R7 upper bits cleared
    drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 3, 1, 0, 0, 0, 1, 3, "R7");
    drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 3, 1, 0, 1, 1, 1, 3, "R7");
    // R8 undefined width flag
    drive(1, 64'h1234, 2, 1, 0, 0, 0, 3, 0, "R8");
    drive(1, 64'h1234, 1, 1, 0, 0, 0, 3, 1, "R8");
    // R9 hold while idle
    idle("R9"); idle("R9"); idle("R9");
    // R1 back-to-back with gaps, random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 5 == 0) idle("R1");
      else drive(1, {$urandom, $urandom}, $urandom % 4, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), $urandom % 4, $urandom % 4, "R4");
    end
    idle("R9"); idle("R9"); idle("R9");
    done = 1;
    finishRun();
  end
endmodule